// File: doc/BRIEF.md
# Address-Range Cache Line Invalidator

This block clears the valid state of cache lines that a byte range can occupy in a direct-mapped cache. A request gives a virtual base address, a byte length and a threshold. The line index comes from address bits 10 down to 4, which gives 128 lines of 16 bytes with the default parameters. The block reads the tag entry at each covered index. When bit 0 of that entry, the valid bit, is set, it writes the entry back as zero. It never compares the stored tag against the request, so any valid line at a covered index is dropped.

A walk costs two or three cycles per line. A long range is cheaper to handle with one whole-cache clear. When the length is larger than the threshold, the block issues a single flash-clear pulse instead of walking. A threshold of zero therefore sends every non-empty request to the flash clear.

The block accepts a request when `start_i` is high while `busy_o` is low. Completion is a one-cycle `done_o` pulse. The tag port is a synchronous-read RAM port: the read data must be valid in the cycle after the one in which `tag_rd_o` is high.

Top module: `line_span_invalidator`

## Requirements
- R1: While reset is held and in the first cycle after it, `busy_o`, `done_o`, `tag_rd_o`, `tag_wr_o` and `flash_clr_o` are all low.
- R2: A walk starts at the index given by address bits 10 to 4 of `base_i`. It reads consecutive indices in increasing order, and each line is read exactly once per pass.
- R3: A walk reads ceil(`len_i` / 16) lines. The length is rounded up to whole 16-byte lines.
- R4: Two cycles after a read, the block writes the same index with all-zero data if bit 0 of the returned tag is 1. If bit 0 is 0, it writes nothing.
- R5: After index 127 the walk continues at index 0. Indices that are visited again in the same request are read again.
- R6: When `len_i` > `thresh_i`, the block gives one `flash_clr_o` pulse in the cycle after the start and no tag reads or writes. `done_o` follows in the next cycle.
- R7: With `thresh_i` = 0, every request with a non-zero length takes the flash-clear path.
- R8: A request with `len_i` = 0 pulses `done_o` in the next cycle. It makes no tag access and no flash clear, and `busy_o` stays low.
- R9: `busy_o` is high from the cycle after an accepted non-empty start until `done_o`. It is low when `done_o` pulses. A `start_i` while busy is ignored.
- R10: `tag_rd_o` and `tag_wr_o` are never high together. `tag_wdata_o` is always zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request strobe, taken when not busy |
| base_i | input | 32 | Virtual base address of the range |
| len_i | input | 16 | Byte length of the range |
| thresh_i | input | 16 | Lengths above this use the flash clear |
| busy_o | output | 1 | Request in progress |
| done_o | output | 1 | One-cycle completion pulse |
| tag_rd_o | output | 1 | Tag read strobe |
| tag_wr_o | output | 1 | Tag write strobe |
| tag_idx_o | output | 7 | Tag entry index for read or write |
| tag_wdata_o | output | 20 | Tag write data (zero) |
| tag_rdata_i | input | 20 | Tag read data, valid the cycle after a read |
| flash_clr_o | output | 1 | Whole-cache clear pulse |

## Verification
The assertions take for granted that the tag RAM returns data exactly one cycle after the read strobe. They also assume that nothing else writes the tag array while a walk runs. The bench's tag RAM model keeps both promises.

The stimulus drives `start_i` only at falling edges. It holds `base_i`, `len_i` and `thresh_i` steady around the start cycle, so the start decode sees stable values. Some stimulus comes in while `busy_o` is high, but only as `start_i` pulses, and these are meant to be ignored.

The expected accesses come from a shadow copy of the valid bits. Revisits after a wrap therefore expect a read with no write.

// File: rtl/lsi_pkg.sv
package lsi_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_CLR,
    ST_RDQ,
    ST_CHK,
    ST_WR
  } lsi_state_e;
endpackage

// File: rtl/lsi_plan.sv
module lsi_plan #(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 16,
  parameter int INDEX_W    = 7,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CNT_W     = LEN_W - OFF_W + 1
) (
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [LEN_W-1:0]   thresh_i,
  output logic [INDEX_W-1:0] start_idx_o,
  output logic [CNT_W-1:0]   line_cnt_o,
  output logic               empty_o,
  output logic               use_clear_o
);
  logic [LEN_W:0] len_up;

  always_comb begin
    len_up      = {1'b0, len_i} + (LEN_W+1)'(LINE_BYTES - 1);
    line_cnt_o  = len_up[LEN_W:OFF_W];
    start_idx_o = base_i[OFF_W +: INDEX_W];
    empty_o     = (len_i == '0);
    use_clear_o = (len_i > thresh_i);
  end
endmodule

// File: rtl/lsi_walker.sv
module lsi_walker #(
  parameter int INDEX_W = 7,
  parameter int CNT_W   = 13
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               load_i,
  input  logic [INDEX_W-1:0] load_idx_i,
  input  logic [CNT_W-1:0]   load_cnt_i,
  input  logic               step_i,
  output logic [INDEX_W-1:0] idx_o,
  output logic               last_o
);
  logic [CNT_W-1:0] remain_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_o    <= '0;
      remain_q <= '0;
    end else if (load_i) begin
      idx_o    <= load_idx_i;
      remain_q <= load_cnt_i;
    end else if (step_i) begin
      idx_o    <= idx_o + 1'b1;
      remain_q <= remain_q - 1'b1;
    end
  end

  assign last_o = (remain_q == CNT_W'(1));

  assert_idx_wraps_R5: assert property (@(posedge clk) disable iff (rst)
    step_i && !load_i |=> idx_o == INDEX_W'($past(idx_o) + 1'b1));
endmodule

// File: rtl/line_span_invalidator.sv
module line_span_invalidator
  import lsi_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int LEN_W      = 16,
  parameter int LINE_BYTES = 16,
  parameter int INDEX_W    = 7,
  parameter int TAG_W      = 20,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int CNT_W     = LEN_W - OFF_W + 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               start_i,
  input  logic [ADDR_W-1:0]  base_i,
  input  logic [LEN_W-1:0]   len_i,
  input  logic [LEN_W-1:0]   thresh_i,
  output logic               busy_o,
  output logic               done_o,
  output logic               tag_rd_o,
  output logic               tag_wr_o,
  output logic [INDEX_W-1:0] tag_idx_o,
  output logic [TAG_W-1:0]   tag_wdata_o,
  input  logic [TAG_W-1:0]   tag_rdata_i,
  output logic               flash_clr_o
);
  lsi_state_e        state_q;
  logic [INDEX_W-1:0] start_idx;
  logic [CNT_W-1:0]   line_cnt;
  logic               empty, use_clear, last;
  logic               accept, load, advance, step;

  lsi_plan #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .LINE_BYTES(LINE_BYTES), .INDEX_W(INDEX_W)
  ) u_plan (
    .base_i(base_i), .len_i(len_i), .thresh_i(thresh_i),
    .start_idx_o(start_idx), .line_cnt_o(line_cnt),
    .empty_o(empty), .use_clear_o(use_clear)
  );

  always_comb begin
    accept  = (state_q == ST_IDLE) && start_i;
    load    = accept && !empty && !use_clear;
    advance = ((state_q == ST_CHK) && !tag_rdata_i[0]) || (state_q == ST_WR);
    step    = advance && !last;
  end

  lsi_walker #(.INDEX_W(INDEX_W), .CNT_W(CNT_W)) u_walk (
    .clk(clk), .rst(rst), .load_i(load), .load_idx_i(start_idx),
    .load_cnt_i(line_cnt), .step_i(step), .idx_o(tag_idx_o), .last_o(last)
  );

  assign tag_wdata_o = '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      busy_o      <= 1'b0;
      done_o      <= 1'b0;
      tag_rd_o    <= 1'b0;
      tag_wr_o    <= 1'b0;
      flash_clr_o <= 1'b0;
    end else begin
      done_o      <= 1'b0;
      tag_rd_o    <= 1'b0;
      tag_wr_o    <= 1'b0;
      flash_clr_o <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          if (empty) begin
            done_o <= 1'b1;
          end else if (use_clear) begin
            flash_clr_o <= 1'b1;
            busy_o      <= 1'b1;
            state_q     <= ST_CLR;
          end else begin
            tag_rd_o <= 1'b1;
            busy_o   <= 1'b1;
            state_q  <= ST_RDQ;
          end
        end
        ST_CLR: begin
          done_o  <= 1'b1;
          busy_o  <= 1'b0;
          state_q <= ST_IDLE;
        end
        ST_RDQ: state_q <= ST_CHK;
        ST_CHK, ST_WR: begin
          if (state_q == ST_CHK && tag_rdata_i[0]) begin
            tag_wr_o <= 1'b1;
            state_q  <= ST_WR;
          end else if (last) begin
            done_o  <= 1'b1;
            busy_o  <= 1'b0;
            state_q <= ST_IDLE;
          end else begin
            tag_rd_o <= 1'b1;
            state_q  <= ST_RDQ;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assert_rd_wr_excl_R10: assert property (@(posedge clk) disable iff (rst)
    !(tag_rd_o && tag_wr_o));
  assert_wr_follows_rd_R4: assert property (@(posedge clk) disable iff (rst)
    $rose(tag_wr_o) |-> $past(tag_rd_o, 2) && $stable(tag_idx_o));
  assert_clr_single_R6: assert property (@(posedge clk) disable iff (rst)
    flash_clr_o |=> !flash_clr_o && done_o && !tag_rd_o);
  assert_done_not_busy_R9: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);
  assert_empty_req_R8: assert property (@(posedge clk) disable iff (rst)
    start_i && !busy_o && (len_i == '0) |=> done_o && !tag_rd_o && !flash_clr_o && !busy_o);
endmodule

// File: tb/line_span_invalidator_bench.sv
module line_span_invalidator_bench;
  localparam int EV_WR = 0, EV_RD = 256, EV_CLR = 1000, EV_DONE = 2000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0;
  logic [31:0] base_i = '0;
  logic [15:0] len_i = '0, thresh_i = '0;
  logic        busy_o, done_o, tag_rd_o, tag_wr_o, flash_clr_o;
  logic [6:0]  tag_idx_o;
  logic [19:0] tag_wdata_o, tag_rdata_i;

  logic [19:0] mem [128];
  int exp_q[$];
  int vectors = 0, errors = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  line_span_invalidator u_line_span_invalidator (
    .clk(clk), .rst(rst), .start_i(start_i), .base_i(base_i), .len_i(len_i),
    .thresh_i(thresh_i), .busy_o(busy_o), .done_o(done_o), .tag_rd_o(tag_rd_o),
    .tag_wr_o(tag_wr_o), .tag_idx_o(tag_idx_o), .tag_wdata_o(tag_wdata_o),
    .tag_rdata_i(tag_rdata_i), .flash_clr_o(flash_clr_o)
  );

  always @(posedge clk) begin
    if (tag_rd_o) tag_rdata_i <= mem[tag_idx_o];
    if (tag_wr_o) mem[tag_idx_o] <= tag_wdata_o;
  end

  task automatic check(input string req, input int act, input int exp);
    vectors++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic observe(input int ev);
    int want;
    if (exp_q.size() == 0) begin
      check("R9 unexpected event", ev, -1);
    end else begin
      want = exp_q.pop_front();
      check("R2 R3 R4 R5 R6 R8 event", ev, want);
    end
  endtask

  always @(negedge clk) begin
    if (!rst) begin
      cycles++;
      if (tag_rd_o) observe(EV_RD + int'(tag_idx_o));
      if (tag_wr_o) begin
        observe(EV_WR + int'(tag_idx_o));
        check("R10 wdata zero", int'(tag_wdata_o), 0);
      end
      if (flash_clr_o) observe(EV_CLR);
      if (done_o) begin
        observe(EV_DONE);
        check("R9 busy low at done", int'(busy_o), 0);
      end
      if (cycles > 150000) begin
        errors++;
        $display("FAIL watchdog actual=%0d expected=done", cycles);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
      end
    end
  end

  task automatic fill(input int seed);
    for (int i = 0; i < 128; i++)
      mem[i] = {12'(i * seed), 7'(i), 1'(((i * seed) % 3) == 0)};
  endtask

  task automatic run_op(input logic [31:0] b, input logic [15:0] l,
                        input logic [15:0] t, input bit poke);
    bit valid [128];
    int idx, n;
    for (int i = 0; i < 128; i++) valid[i] = mem[i][0];
    if (l == 0) begin
      exp_q.push_back(EV_DONE);
    end else if (l > t) begin
      exp_q.push_back(EV_CLR);
      exp_q.push_back(EV_DONE);
    end else begin
      idx = int'(b[10:4]);
      n = (int'(l) + 15) / 16;
      for (int k = 0; k < n; k++) begin
        exp_q.push_back(EV_RD + idx);
        if (valid[idx]) begin
          exp_q.push_back(EV_WR + idx);
          valid[idx] = 1'b0;
        end
        idx = (idx + 1) % 128;
      end
      exp_q.push_back(EV_DONE);
    end
    @(negedge clk);
    base_i = b; len_i = l; thresh_i = t; start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    if (poke && busy_o) begin
      @(negedge clk);
      check("R9 busy during walk", int'(busy_o), 1);
      base_i = 32'h0000_0350; len_i = 16'd0; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
    end
    while (exp_q.size() != 0) @(negedge clk);
    repeat (3) @(negedge clk);
    check("R9 no stray events", exp_q.size(), 0);
  endtask

  initial begin
    fill(1);
    repeat (3) @(negedge clk);
    check("R1 busy", int'(busy_o), 0);
    check("R1 done", int'(done_o), 0);
    check("R1 rd", int'(tag_rd_o), 0);
    check("R1 wr", int'(tag_wr_o), 0);
    check("R1 clr", int'(flash_clr_o), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset", int'({busy_o, done_o, tag_rd_o, tag_wr_o, flash_clr_o}), 0);
    // R2 R3 R4: short walk, odd length rounded up
    run_op(32'h1234_5678, 16'd37, 16'd512, 1'b0);
    fill(2);
    run_op(32'h0000_0020, 16'd16, 16'd512, 1'b0);
    fill(5);
    run_op(32'h0000_0001, 16'd1, 16'd64, 1'b0);
    // R5: wrap from line 127 to line 0
    fill(7);
    run_op(32'hABCD_07E0, 16'd80, 16'd512, 1'b0);
    // R5: range longer than the cache revisits lines
    fill(1);
    run_op(32'h0000_0400, 16'd2100, 16'd4096, 1'b0);
    // R6: length above threshold takes flash clear
    fill(3);
    run_op(32'h0000_0100, 16'd65, 16'd64, 1'b0);
    // R6 boundary: length equal to threshold walks
    run_op(32'h0000_0100, 16'd64, 16'd64, 1'b0);
    // R7: zero threshold
    run_op(32'h0000_0200, 16'd1, 16'd0, 1'b0);
    // R8: zero length, even with zero threshold
    run_op(32'h0000_0300, 16'd0, 16'd0, 1'b0);
    run_op(32'h0000_0300, 16'd0, 16'd100, 1'b0);
    // R9: start while busy is ignored
    fill(4);
    run_op(32'h0000_0040, 16'd96, 16'd512, 1'b1);
    fill(6);
    run_op(32'h0000_0700, 16'd256, 16'd300, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule